// File: doc/BRIEF.md
# MDIO Management Master

This block is a memory-mapped master for the two-wire PHY management bus. It runs both the short-form (Clause 22) frame and the extended-address (Clause 45) frame. Software loads a small set of registers with the PHY port, the register or device number and any write data. It then writes a start command and polls a busy flag. Each accepted command produces exactly one serial frame on MDC/MDIO. The frame is a 32-bit preamble of ones, start and opcode fields, two 5-bit address fields, a 2-bit turnaround and 16 data bits.

MDC is made by dividing the 100 MHz source clock by the parameter `DIV`. The default of 40 gives 2.5 MHz. The data pad is split into output, output-enable and input. During the turnaround and data phases of a read, the master releases the pad and shifts in 16 bits from the PHY. Those bits land in the read-data register when the frame ends.

In Clause 45 mode the same command access code selects an address frame, a write frame or a read frame. An extended read is therefore two commands in a row: an address frame that carries the target register, then a read frame.

Top module: `mdio_master`

## Requirements
- R1: After reset, MDC, MDIO output enable and the busy flag are 0, and every register reads 0.
- R2: MDC repeats every `DIV` source cycles. It is low for the first `DIV/2` cycles and high for the rest, and the first high phase begins `DIV/2` cycles after reset is released.
- R3: Registers are decoded by byte offset. 0x40 is mode, where bit 8 = 1 selects Clause 45 frames. 0x44 is address, with the PHY port in bits 12:8 and the register or device number in bits 4:0. 0x48 is write data, bits 15:0. 0x4C is read data, bits 15:0. 0x50 is command: writing bit 8 starts a command, bits 1:0 are the access code, and bit 16 reads as busy. Unimplemented bits read 0.
- R4: A start write accepted while idle sets busy from the next cycle. The frame begins at the next MDC falling edge and lasts 64 MDC periods. Busy clears at the MDC falling edge that ends the last bit.
- R5: In Clause 22 mode the frame is 32 ones, start 01, then opcode 01 (write, code 1) or 10 (read, any other code), then PHY[4:0], register[4:0], turnaround and 16 data bits, all MSB first.
- R6: In Clause 45 mode the start field is 00. The opcode is 00 for code 0 (address frame, where the data field is write-data[15:0]), 01 for code 1 (write) and 11 for codes 2 and 3 (read).
- R7: MDIO output and output enable change only on the MDC falling edge. MDIO input is sampled just before the MDC rising edge. The 16 bits sampled in a read's data phase appear MSB first in read-data[15:0] after busy clears.
- R8: A write or address frame drives 10 in the turnaround and then the data. A read frame drops output enable for its last 18 bits.
- R9: A start write while busy is ignored: no second frame, and the command access code reads back unchanged.
- R10: Writes to mode, address or write data during a frame update the registers but leave the frame in flight unchanged.
- R11: Output enable is 0 whenever busy is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 100 MHz source clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data pad output value |
| mdio_oe | output | 1 | Data pad output enable |
| mdio_i | input | 1 | Data pad input value |

## Verification
A register write from software and the frame sequencer's use of those same registers can fall in the same span of cycles. The bench provokes this in the middle of a Clause 22 write frame. It issues a second start command and rewrites address, write data and mode there. It then judges two things: the PHY model's captured frame must match the one that was launched, and the busy flag must stay low after the first frame. A clock-by-clock busy and MDC reference independently confirms that no second frame began. It also confirms that the new register values read back afterwards.

// File: rtl/mdio_master.sv
module mdio_master #(
  parameter int DIV = 40,
  parameter int AW  = 8,
  parameter int DW  = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          mdc,
  output logic          mdio_o,
  output logic          mdio_oe,
  input  logic          mdio_i
);
  localparam int HALF = DIV / 2;
  localparam int CW   = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [AW-1:0] OFS_MODE = AW'(8'h40);
  localparam logic [AW-1:0] OFS_ADDR = AW'(8'h44);
  localparam logic [AW-1:0] OFS_WDAT = AW'(8'h48);
  localparam logic [AW-1:0] OFS_RDAT = AW'(8'h4C);
  localparam logic [AW-1:0] OFS_CMD  = AW'(8'h50);

  logic [CW-1:0] cnt;
  logic          mdc_q;
  logic          c45_q;
  logic [4:0]    phy_q, reg_q;
  logic [15:0]   wd_q, rd_q, sh_q;
  logic [1:0]    code_q;
  logic          busy, active, is_rd;
  logic [5:0]    idx;
  logic [63:0]   frame_q;

  wire fall_t = (cnt == CW'(DIV - 1));
  wire rise_t = (cnt == CW'(HALF - 1));
  wire start  = bus_we && (bus_addr == OFS_CMD) && bus_wdata[8] && !busy;

  wire [1:0] code_n = bus_wdata[1:0];
  logic        rd_n;
  logic [1:0]  st_n, op_n;
  always_comb begin
    if (c45_q) begin
      st_n = 2'b00;
      rd_n = code_n[1];
      case (code_n)
        2'd0:    op_n = 2'b00;
        2'd1:    op_n = 2'b01;
        default: op_n = 2'b11;
      endcase
    end else begin
      st_n = 2'b01;
      rd_n = (code_n != 2'd1);
      op_n = rd_n ? 2'b10 : 2'b01;
    end
  end
  wire [63:0] frame_n = {32'hFFFF_FFFF, st_n, op_n, phy_q, reg_q,
                         rd_n ? 2'b11 : 2'b10, rd_n ? 16'hFFFF : wd_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt <= fall_t ? '0 : cnt + 1'b1;
      if (rise_t)      mdc_q <= 1'b1;
      else if (fall_t) mdc_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c45_q <= 1'b0;
      phy_q <= '0;
      reg_q <= '0;
      wd_q  <= '0;
    end else if (bus_we) begin
      case (bus_addr)
        OFS_MODE: c45_q <= bus_wdata[8];
        OFS_ADDR: begin phy_q <= bus_wdata[12:8]; reg_q <= bus_wdata[4:0]; end
        OFS_WDAT: wd_q  <= bus_wdata[15:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      active  <= 1'b0;
      is_rd   <= 1'b0;
      idx     <= '0;
      frame_q <= '0;
      code_q  <= '0;
      mdio_o  <= 1'b0;
      mdio_oe <= 1'b0;
      rd_q    <= '0;
      sh_q    <= '0;
    end else begin
      if (start) begin
        busy    <= 1'b1;
        frame_q <= frame_n;
        is_rd   <= rd_n;
        code_q  <= code_n;
      end
      if (busy && fall_t) begin
        if (!active) begin
          active  <= 1'b1;
          idx     <= '0;
          mdio_o  <= frame_q[63];
          mdio_oe <= 1'b1;
          frame_q <= frame_q << 1;
        end else if (idx == 6'd63) begin
          active  <= 1'b0;
          busy    <= 1'b0;
          mdio_oe <= 1'b0;
          if (is_rd) rd_q <= sh_q;
        end else begin
          idx     <= idx + 1'b1;
          mdio_o  <= frame_q[63];
          mdio_oe <= !(is_rd && idx >= 6'd45);
          frame_q <= frame_q << 1;
        end
      end
      if (active && rise_t && idx >= 6'd48)
        sh_q <= {sh_q[14:0], mdio_i};
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFS_MODE: bus_rdata[8]    = c45_q;
      OFS_ADDR: begin bus_rdata[12:8] = phy_q; bus_rdata[4:0] = reg_q; end
      OFS_WDAT: bus_rdata[15:0] = wd_q;
      OFS_RDAT: bus_rdata[15:0] = rd_q;
      OFS_CMD:  begin bus_rdata[16] = busy; bus_rdata[1:0] = code_q; end
      default: ;
    endcase
  end

  assign mdc = mdc_q;
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
  input logic clk,
  input logic rst_n,
  input logic mdc,
  input logic mdio_o,
  input logic mdio_oe,
  input logic busy,
  input logic start
);
  p_out_on_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mdio_o) |-> $fell(mdc));
  p_oe_on_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mdio_oe) |-> $fell(mdc));
  p_idle_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdio_oe);
  p_start_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);
  p_busy_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $fell(mdc));
endmodule

bind mdio_master mdio_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mdc(mdc), .mdio_o(mdio_o),
  .mdio_oe(mdio_oe), .busy(busy), .start(start)
);

// File: tb/tb_mdio_master.sv
`timescale 1ns/1ps
module tb_mdio_master;
  localparam int DIV  = 4;
  localparam int HALF = DIV / 2;
  localparam logic [7:0] A_MODE = 8'h40, A_ADDR = 8'h44, A_WDAT = 8'h48,
                         A_RDAT = 8'h4C, A_CMD = 8'h50;

  logic clk = 0, rst_n = 0, bus_we = 0, mdio_i = 1;
  logic [7:0]  bus_addr = A_CMD;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic mdc, mdio_o, mdio_oe;

  int checks = 0, errors = 0;
  bit done = 0;

  mdio_master #(.DIV(DIV)) dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i));

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model: edges since reset, busy window
  int ecount = 0;
  bit ref_busy = 0;
  int ref_end = 0;
  always @(posedge clk) begin
    if (rst_n) begin
      ecount <= ecount + 1;
      if (bus_we && bus_addr == A_CMD && bus_wdata[8] && !ref_busy) begin
        ref_busy <= 1;
        ref_end  <= ((ecount + 1) / DIV + 1) * DIV + 64 * DIV;
      end else if (ref_busy && ecount + 1 == ref_end)
        ref_busy <= 0;
    end
  end

  always @(negedge clk) begin
    #2;
    if (rst_n && !done) begin
      bit exp_mdc;
      exp_mdc = (ecount == 0) ? 0 :
                (((ecount - 1) % DIV) >= HALF - 1 && ((ecount - 1) % DIV) <= DIV - 2);
      chk(mdc == exp_mdc, "R2 mdc", mdc, exp_mdc);
      if (!ref_busy) chk(!mdio_oe, "R11 oe idle", mdio_oe, 0);
      if (!bus_we && bus_addr == A_CMD)
        chk(bus_rdata[16] == ref_busy, "R4 busy", bus_rdata[16], ref_busy);
    end
  end

  // PHY model
  logic [63:0] seen, oe_seen;
  int pos = 0, frames = 0;
  bit in_frame = 0, phy_rd = 0;
  logic [15:0] phy_val = 0;
  always @(posedge mdc) begin
    if (!in_frame && mdio_oe) begin in_frame = 1; pos = 0; end
    if (in_frame) begin
      seen[63-pos]    = mdio_oe ? mdio_o : 1'b0;
      oe_seen[63-pos] = mdio_oe;
      pos++;
      if (pos == 64) begin in_frame = 0; frames++; end
    end
  end
  always @(negedge mdc) begin
    if (in_frame && phy_rd && pos >= 47)
      mdio_i = (pos == 47) ? 1'b0 : phy_val[15-(pos-48)];
    else
      mdio_i = 1'b1;
  end

  function automatic logic [63:0] exp_frame(bit c45, logic [1:0] code, logic [4:0] phy,
                                            logic [4:0] rg, logic [15:0] d);
    logic [1:0] st, op; bit rd;
    if (c45) begin
      st = 2'b00; rd = code[1];
      op = (code == 0) ? 2'b00 : (code == 1) ? 2'b01 : 2'b11;
    end else begin
      st = 2'b01; rd = (code != 1); op = rd ? 2'b10 : 2'b01;
    end
    return {32'hFFFF_FFFF, st, op, phy, rg, rd ? 2'b00 : 2'b10, rd ? 16'h0 : d};
  endfunction

  function automatic logic [63:0] exp_mask(bit rd);
    return rd ? {46'h3FFF_FFFF_FFFF, 18'h0} : 64'hFFFF_FFFF_FFFF_FFFF;
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 0; bus_addr = A_CMD;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    bus_addr = a;
    #1;
    chk(bus_rdata == e, tag, bus_rdata, e);
    bus_addr = A_CMD;
  endtask

  task automatic wait_idle();
    int n;
    n = 0;
    @(negedge clk);
    while (ref_busy && n < 2000) begin @(negedge clk); n++; end
    repeat (2) @(negedge clk);
  endtask

  task automatic frame(input bit c45, input logic [1:0] code, input logic [4:0] phy,
                       input logic [4:0] rg, input logic [15:0] d, input bit isrd,
                       input string tag);
    logic [63:0] ef, em;
    ef = exp_frame(c45, code, phy, rg, d);
    em = exp_mask(isrd);
    seen = 0; oe_seen = 0;
    wr(A_CMD, {23'h0, 1'b1, 6'h0, code});
    wait_idle();
    chk(oe_seen == em, {tag, " oe"}, oe_seen, em);
    chk((seen & em) == ef, {tag, " bits"}, seen & em, ef);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int f0;
    repeat (3) @(negedge clk);
    chk(mdc == 0, "R1 mdc", mdc, 0);
    chk(mdio_oe == 0, "R1 oe", mdio_oe, 0);
    rd(A_MODE, 0, "R1 mode"); rd(A_ADDR, 0, "R1 addr"); rd(A_WDAT, 0, "R1 wdat");
    rd(A_RDAT, 0, "R1 rdat"); rd(A_CMD, 0, "R1 cmd");
    @(negedge clk); rst_n = 1;

    // R3 register map
    wr(A_MODE, 32'hFFFF_FFFF); rd(A_MODE, 32'h100, "R3 mode");
    wr(A_ADDR, 32'hFFFF_FFFF); rd(A_ADDR, 32'h1F1F, "R3 addr");
    wr(A_WDAT, 32'h1234_ABCD); rd(A_WDAT, 32'hABCD, "R3 wdat");
    wr(A_MODE, 0);

    // R5 R8 Clause 22 write
    wr(A_ADDR, 32'h050A); wr(A_WDAT, 32'hBEEF); phy_rd = 0;
    frame(0, 2'd1, 5'h05, 5'h0A, 16'hBEEF, 0, "R5 R8 c22 write");
    rd(A_CMD, 32'h1, "R3 cmd code");

    // R5 R7 R8 Clause 22 read
    wr(A_ADDR, 32'h1103); phy_rd = 1; phy_val = 16'h5A3C;
    frame(0, 2'd0, 5'h11, 5'h03, 0, 1, "R5 R8 c22 read");
    rd(A_RDAT, 32'h5A3C, "R7 c22 read data");
    phy_val = 16'h8001;
    frame(0, 2'd2, 5'h11, 5'h03, 0, 1, "R5 c22 code2 read");
    rd(A_RDAT, 32'h8001, "R7 read data edge bits");

    // R6 Clause 45 address, read, write
    wr(A_MODE, 32'h100); wr(A_ADDR, 32'h0207); wr(A_WDAT, 32'h1234); phy_rd = 0;
    frame(1, 2'd0, 5'h02, 5'h07, 16'h1234, 0, "R6 c45 address");
    phy_rd = 1; phy_val = 16'hC0DE;
    frame(1, 2'd2, 5'h02, 5'h07, 0, 1, "R6 c45 read");
    rd(A_RDAT, 32'hC0DE, "R7 c45 read data");
    phy_val = 16'h0F0F;
    frame(1, 2'd3, 5'h02, 5'h07, 0, 1, "R6 c45 code3 read");
    phy_rd = 0; wr(A_WDAT, 32'hA5A5);
    frame(1, 2'd1, 5'h02, 5'h07, 16'hA5A5, 0, "R6 c45 write");
    rd(A_RDAT, 32'h0F0F, "R8 write keeps read data");

    // R9 R10 activity during a frame
    wr(A_MODE, 0); wr(A_ADDR, 32'h0C15); wr(A_WDAT, 32'h3C3C);
    seen = 0; oe_seen = 0; f0 = frames;
    wr(A_CMD, 32'h101);
    repeat (60) @(negedge clk);
    wr(A_CMD, 32'h102);
    wr(A_ADDR, 32'h1F01); wr(A_WDAT, 32'hFFFF); wr(A_MODE, 32'h100);
    wait_idle();
    chk((seen) == exp_frame(0, 2'd1, 5'h0C, 5'h15, 16'h3C3C), "R10 frame intact",
        seen, exp_frame(0, 2'd1, 5'h0C, 5'h15, 16'h3C3C));
    rd(A_CMD, 32'h1, "R9 code unchanged");
    repeat (80 * DIV) @(negedge clk);
    chk(frames == f0 + 1, "R9 no second frame", frames, f0 + 1);
    rd(A_ADDR, 32'h1F01, "R10 addr updated");
    rd(A_WDAT, 32'hFFFF, "R10 wdat updated");
    rd(A_MODE, 32'h100, "R10 mode updated");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule